// File: doc/BRIEF.md
# Multi-Device Converter Phase Synchronizer

This block keeps the internal timing of one data converter in step with other converters that share the same sample clock. A 16-state phase counter advances once per converter update clock. Every timing output comes from this counter: a strobe at the channel data rate that latches input samples, a modulator coefficient index, and an optional reference clock for other devices.

A device can run as a master or as a slave. A master drives its reference pin with a square wave. That wave is either one full counter period long or one channel-data period long. A slave takes the reference from a master. In modulator-reference mode the slave restarts its phase counter on each detected rising edge. In data-clock-reference mode the slave realigns only its channel-rate strobe. A third setting turns the reference pin into a pass-through for a PLL lock flag and disables synchronization.

Settings come through a small register write port:
- an operating mode,
- the interpolation factor (the channel-rate period),
- a signed strobe skew in update-clock cycles,
- a coefficient alignment offset, which waits for the next counter wrap before it takes effect.

Top module: `phase_sync_top`

## Requirements
- R1: After reset the phase counter advances by one per clock, modulo 16, unless a slave realignment occurs. `coef_idx` always equals (counter + active coefficient offset) mod 16.
- R2: While reset is held, and in the first cycle after it, `coef_idx`, `chan_strobe`, `ref_out`, `ref_oe` and `locked` are 0. Reset also clears both offsets and selects data-clock master mode with a rate factor of 2.
- R3: A write with `wr_en`=1 updates one register per clock, selected by `wr_addr`:
  - Address 0 is the mode: bit 0 is the lock-flag select, bit 1 selects an external reference, bit 2 selects the modulator reference, and bit 3 is accepted with no effect.
  - Address 1 is the 4-bit two's-complement strobe skew.
  - Address 2 is the 4-bit coefficient offset.
  - Address 3 is the rate select in bits 1:0: 0 gives factor 2, 1 gives factor 4, and 2 or 3 gives factor 8.
- R4: In modulator-master mode (mode bits 2:0 = 100), `ref_out` is high while the counter is in states 0 to 7 and low in states 8 to 15. Its rising edge coincides with state zero.
- R5: In data-clock-master mode (mode bits 2:0 = 000), `ref_out` is high for the first half of each channel period. That is, it is high when (counter mod F) < F/2, where F is the rate factor.
- R6: `chan_strobe` is high in the cycle where (channel phase + skew) mod F = 0. Outside data-clock slave mode, the channel phase equals the phase counter.
- R7: A new coefficient offset stays pending until the counter next enters state zero. From that cycle on, `coef_idx` uses the new offset.
- R8: In modulator-slave mode (mode bits 2:0 = 110), a rising edge of `ref_in` sampled at clock edge k puts the counter in state zero after edge k+2.
- R9: In data-clock-slave mode (mode bits 2:0 = 010), a rising reference edge sampled at edge k restarts only the channel phase, after edge k+2. `coef_idx` continues undisturbed.
- R10: In a slave mode, `locked` is set when two consecutive detected reference edges each land where the realigned phase would wrap to zero anyway. Once set, it stays set until reset.
- R11: With the lock-flag select set, `ref_out` follows `pll_lock_in` one clock later and `ref_in` has no effect. `ref_oe` is 1 in master and lock-flag modes and 0 in slave modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter update clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 4 | Register write value |
| pll_lock_in | input | 1 | PLL lock status, forwarded in lock-flag mode |
| ref_in | input | 1 | Reference clock from a master device |
| ref_out | output | 1 | Reference clock or lock flag toward other devices |
| ref_oe | output | 1 | Output enable for the shared reference pin |
| chan_strobe | output | 1 | One-cycle strobe at the channel data rate |
| coef_idx | output | 4 | Modulator coefficient index |
| locked | output | 1 | Sticky slave alignment status |

## Verification
The free-running counter is exercised in both master waveforms and at every rate factor. This separates a half-period error from a full-period error in the reference output. Positive and negative skews are both applied, so a missing sign extension shows up as a shifted strobe. In each slave mode a reference train starts at a phase that disagrees with the free-running counter. Modulator-reference mode must then move `coef_idx`, while data-clock-reference mode must move only the strobe. The coefficient offset is written mid-period to show that it waits for the wrap. Reference pulses are also sent in lock-flag mode to show that they are ignored.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef enum logic [2:0] {
    M_FLAG,
    M_DC_MASTER,
    M_MOD_MASTER,
    M_DC_SLAVE,
    M_MOD_SLAVE
  } sync_mode_e;

  // bit0: lock-flag select, bit1: external reference, bit2: modulator reference
  function automatic sync_mode_e decode_mode(input logic [2:0] bits);
    if (bits[0]) return M_FLAG;
    if (!bits[1]) return bits[2] ? M_MOD_MASTER : M_DC_MASTER;
    return bits[2] ? M_MOD_SLAVE : M_DC_SLAVE;
  endfunction

  // log2 of the channel-rate factor
  function automatic logic [1:0] rate_log(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/ps_regs.sv
module ps_regs
  import ps_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output sync_mode_e       mode,
  output logic [OFF_W-1:0] skew,
  output logic [CNT_W-1:0] coef_pend,
  output logic [1:0]       rate_lg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_DC_MASTER;
      skew      <= '0;
      coef_pend <= '0;
      rate_lg   <= 2'd1;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: mode      <= decode_mode(wr_data[2:0]);
        2'd1: skew      <= wr_data[OFF_W-1:0];
        2'd2: coef_pend <= wr_data;
        default: rate_lg <= rate_log(wr_data[1:0]);
      endcase
    end
  end

endmodule

// File: rtl/ps_refsync.sv
module ps_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise
);

  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], ref_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;

endmodule

// File: rtl/ps_phase.sv
module ps_phase
  import ps_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sync_mode_e       mode,
  input  logic [OFF_W-1:0] skew,
  input  logic [CNT_W-1:0] coef_pend,
  input  logic [1:0]       rate_lg,
  input  logic             rise,
  input  logic             pll_lock_in,
  output logic             ref_out,
  output logic             ref_oe,
  output logic             chan_strobe,
  output logic [CNT_W-1:0] coef_idx,
  output logic             locked,
  output logic [CNT_W-1:0] cnt_q,
  output logic             force_cnt,
  output logic [CNT_W-1:0] coef_act
);

  logic [CNT_W-1:0] ch_q, cnt_next, ch_next, mask, coef_act_n, skew_ext;
  logic             slave_mod, slave_dc, is_slave, force_ch, match, hit, half_hi;
  logic             ref_n;

  assign slave_mod = (mode == M_MOD_SLAVE);
  assign slave_dc  = (mode == M_DC_SLAVE);
  assign is_slave  = slave_mod | slave_dc;
  assign force_cnt = rise & slave_mod;
  assign force_ch  = rise & is_slave;

  assign cnt_next = force_cnt ? '0 : cnt_q + 1'b1;
  assign ch_next  = force_ch  ? '0 : ch_q + 1'b1;
  assign mask     = (CNT_W'(1) << rate_lg) - 1'b1;
  assign skew_ext = CNT_W'($signed(skew));
  assign half_hi  = |(cnt_next & mask & ~(mask >> 1));

  assign coef_act_n = (cnt_next == '0) ? coef_pend : coef_act;
  assign match = slave_mod ? (cnt_q == '1) : (((ch_q + 1'b1) & mask) == '0);

  always_comb begin
    case (mode)
      M_FLAG:       ref_n = pll_lock_in;
      M_DC_MASTER:  ref_n = ~half_hi;
      M_MOD_MASTER: ref_n = ~cnt_next[CNT_W-1];
      default:      ref_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      ch_q        <= '0;
      coef_act    <= '0;
      coef_idx    <= '0;
      chan_strobe <= 1'b0;
      ref_out     <= 1'b0;
      ref_oe      <= 1'b0;
      hit         <= 1'b0;
      locked      <= 1'b0;
    end else begin
      cnt_q       <= cnt_next;
      ch_q        <= ch_next;
      coef_act    <= coef_act_n;
      coef_idx    <= cnt_next + coef_act_n;
      chan_strobe <= (((ch_next + skew_ext) & mask) == '0);
      ref_out     <= ref_n;
      ref_oe      <= ~is_slave;
      if (force_ch) begin
        hit    <= match;
        locked <= locked | (match & hit);
      end
    end
  end

endmodule

// File: rtl/phase_sync_top.sv
module phase_sync_top
  import ps_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int OFF_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pll_lock_in,
  input  logic             ref_in,
  output logic             ref_out,
  output logic             ref_oe,
  output logic             chan_strobe,
  output logic [CNT_W-1:0] coef_idx,
  output logic             locked
);

  sync_mode_e       mode_w;
  logic [OFF_W-1:0] skew_w;
  logic [CNT_W-1:0] coef_pend_w, cnt_w, coef_act_w;
  logic [1:0]       rate_w;
  logic             rise_w, force_w;

  ps_regs #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode_w), .skew(skew_w), .coef_pend(coef_pend_w), .rate_lg(rate_w)
  );

  ps_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_in(ref_in), .rise(rise_w)
  );

  ps_phase #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_phase (
    .clk(clk), .rst(rst), .mode(mode_w), .skew(skew_w), .coef_pend(coef_pend_w),
    .rate_lg(rate_w), .rise(rise_w), .pll_lock_in(pll_lock_in),
    .ref_out(ref_out), .ref_oe(ref_oe), .chan_strobe(chan_strobe),
    .coef_idx(coef_idx), .locked(locked), .cnt_q(cnt_w), .force_cnt(force_w),
    .coef_act(coef_act_w)
  );

endmodule

// File: rtl/ps_sync_chk.sv
module ps_sync_chk
  import ps_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input sync_mode_e       mode,
  input logic [CNT_W-1:0] cnt,
  input logic             force_zero,
  input logic [CNT_W-1:0] coef_act,
  input logic             rise,
  input logic             ref_out,
  input logic             ref_oe,
  input logic             locked
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(force_zero)) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  // R8
  cnt_force_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_zero)) |-> cnt == '0);

  // R4
  mod_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_MOD_MASTER) |-> ref_out == !cnt[CNT_W-1]);

  // R7
  coef_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && coef_act != $past(coef_act)) |-> cnt == '0);

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R10
  lock_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(locked)) |-> $past(rise));

  // R11
  slave_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == M_DC_SLAVE || $past(mode) == M_MOD_SLAVE)) |-> !ref_oe);

endmodule

bind phase_sync_top ps_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_w), .cnt(cnt_w), .force_zero(force_w),
  .coef_act(coef_act_w), .rise(rise_w), .ref_out(ref_out), .ref_oe(ref_oe),
  .locked(locked)
);

// File: tb/phase_sync_top_test.sv
module phase_sync_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       pll_lock_in = 1'b0;
  logic       ref_in = 1'b0;
  logic       ref_out, ref_oe, chan_strobe, locked;
  logic [3:0] coef_idx;
  int n = 0, tests = 0, fails = 0;

  always #4 clk = ~clk;

  phase_sync_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_lock_in(pll_lock_in), .ref_in(ref_in), .ref_out(ref_out), .ref_oe(ref_oe),
    .chan_strobe(chan_strobe), .coef_idx(coef_idx), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; ref_in = 1'b0; pll_lock_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 coef", coef_idx, 0);
    chk("R2 strobe", chan_strobe, 0);
    chk("R2 ref_out", ref_out, 0);
    chk("R2 ref_oe", ref_oe, 0);
    chk("R2 locked", locked, 0);
  endtask

  task automatic t_free();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step();
      chk("R1 coef", coef_idx, n % 16);
      chk("R5 dc master ref", ref_out, int'(n % 2 == 0));
      chk("R6 strobe f2", chan_strobe, int'(n % 2 == 0));
      chk("R11 master oe", ref_oe, 1);
    end
  endtask

  task automatic t_modmaster();
    do_reset();
    wr(2'd0, 4'h4);
    for (int i = 0; i < 40; i++) begin
      step();
      chk("R4 mod master ref", ref_out, int'((n % 16) < 8));
    end
    wr(2'd3, 4'h1);
    wr(2'd0, 4'h0);
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R5 dc master f4", ref_out, int'((n % 4) < 2));
    end
  endtask

  task automatic t_offset();
    do_reset();
    wr(2'd3, 4'h2);
    wr(2'd1, 4'h3);
    for (int i = 0; i < 16; i++) begin
      step();
      chk("R6 skew +3 f8", chan_strobe, int'((n + 3) % 8 == 0));
    end
    wr(2'd1, 4'hF);
    for (int i = 0; i < 16; i++) begin
      step();
      chk("R6 skew -1 f8", chan_strobe, int'((n + 15) % 8 == 0));
    end
    wr(2'd3, 4'h1);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R3 rate sel 1", chan_strobe, int'((n + 15) % 4 == 0));
    end
  endtask

  task automatic t_coef();
    do_reset();
    step(); step(); step();
    wr(2'd2, 4'h5);
    for (int i = 0; i < 40; i++) begin
      step();
      chk("R7 coef offset", coef_idx, (n >= 16) ? (n + 5) % 16 : n % 16);
    end
  endtask

  task automatic t_modslave();
    int n0;
    do_reset();
    wr(2'd0, 4'h6);
    repeat (4) step();
    n0 = n;
    for (int i = 0; i < 56; i++) begin
      ref_in = (i % 16) < 8;
      step();
      if (n >= n0 + 3) chk("R8 slave realign", coef_idx, (n - n0 - 3) % 16);
      if (n == n0 + 19) chk("R10 not yet locked", locked, 0);
      if (n == n0 + 35) chk("R10 locked", locked, 1);
    end
    chk("R11 slave oe", ref_oe, 0);
    chk("R10 stays locked", locked, 1);
  endtask

  task automatic t_dcslave();
    int n0;
    do_reset();
    wr(2'd0, 4'h2);
    wr(2'd3, 4'h1);
    while ((n + 3) % 4 != 2) step();
    n0 = n;
    for (int i = 0; i < 40; i++) begin
      ref_in = (i % 4) < 2;
      step();
      chk("R9 coef untouched", coef_idx, n % 16);
      if (n >= n0 + 3) chk("R9 strobe realign", chan_strobe, int'((n - n0 - 3) % 4 == 0));
    end
    chk("R10 dc slave locked", locked, 1);
  endtask

  task automatic t_flag();
    do_reset();
    wr(2'd0, 4'h7);
    pll_lock_in = 1'b1;
    step();
    chk("R11 flag high", ref_out, 1);
    chk("R11 flag oe", ref_oe, 1);
    pll_lock_in = 1'b0;
    step();
    chk("R11 flag low", ref_out, 0);
    for (int i = 0; i < 40; i++) begin
      ref_in = (i % 16) < 8;
      step();
      chk("R11 ref ignored", coef_idx, n % 16);
    end
    chk("R11 no lock", locked, 0);
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_free();
    t_modmaster();
    t_offset();
    t_coef();
    t_modslave();
    t_dcslave();
    t_flag();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule